// File: doc/BRIEF.md
# Regulator Voltage Ramp Sequencer

This block drives the output-voltage setpoint code of a single step-down regulator channel. Rather than jumping to a new voltage, it walks a 6-bit setpoint code toward the chosen target one code at a time, taking at most one step per interval tick. One code stands for 25 mV. The target comes from one of three sources: a normal-mode preset, a standby preset, or a preset picked by an external voltage-scaling pin. Turning the channel on starts the code from zero, so the same ramp also acts as a soft start.

Parameters select the channel variant. The step interval is either a register field or a fixed compile-time count; the fixed count defaults to 4.0 µs at a 250 MHz system clock. The voltage-scaling pin may be present or absent. The high-range output select may be present or absent.

Top module: `vramp_seq`

## Requirements
- R1: While reset is held, and after reset until the block is enabled, `code_o`, `busy_o` and `range_o` read 0.
- R2: Every change of `code_o` while enabled is exactly +1 or -1 and moves toward the selected target. Starting from 0 at enable, the code climbs until it equals the target.
- R3: In the programmable variant with step field value T, the first step after `en_i` rises appears T+2 clocks after the first rising edge that samples `en_i` high. Later steps follow every T+1 clocks.
- R4: In the fixed variant, the interval is FIXED_TC+1 clocks whatever `step_tc_i` holds. The first step lands FIXED_TC+2 clocks after enable.
- R5: Target priority is as follows. When the scaling pin is present and `dvs_sel_i`=1, the target is `tgt_dvs_i`. Otherwise, when `stby_sel_i`=1, the target is `tgt_stby_i`. Otherwise the target is `tgt_norm_i`.
- R6: In a channel built without the scaling pin, `dvs_sel_i` and `tgt_dvs_i` have no effect on the target.
- R7: If the selected target changes in the middle of a ramp, the next step goes toward the new target. No code is skipped, and the spacing of steps is kept.
- R8: The code saturates at 0 and 63. It never wraps, and it holds once it equals the target.
- R9: While enabled, `busy_o` is 1 exactly when `code_o` differs from the selected target.
- R10: One clock after `en_i` is sampled low, `code_o` is 0 and `busy_o` is 0.
- R11: In the high-range variant, `range_o` equals `hi_range_i` delayed by one clock. In the single-range variant, `range_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Channel enable; a rising edge starts the soft-start ramp |
| stby_sel_i | input | 1 | Selects the standby preset instead of the normal one |
| dvs_sel_i | input | 1 | Scaling pin; selects the alternate preset when that preset is built in |
| tgt_norm_i | input | CODE_W | Normal-mode target code |
| tgt_stby_i | input | CODE_W | Standby target code |
| tgt_dvs_i | input | CODE_W | Pin-selected target code |
| hi_range_i | input | 1 | High output range select |
| step_tc_i | input | TICK_W | Step interval terminal count; the interval is this value plus one clocks |
| code_o | output | CODE_W | Current setpoint code |
| range_o | output | 1 | Registered range flag |
| busy_o | output | 1 | Ramp in progress |

## Verification
The hardest case to reach is a reversal in the middle of a ramp. The target must change in the cycle right after a step and before the next tick, and that has to be checked against the tick phase, which is not visible at the ports. The bench waits for the code to reach a chosen midpoint, changes the selection at that negedge, and then requires the very next change to be one code in the opposite direction, with the spacing still equal to the interval. The soft-start timing is swept over every target code and several interval values, and each cycle is compared with a closed-form count of elapsed ticks.

// File: rtl/vramp_pkg.sv
// Shared types for the voltage ramp sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package vramp_pkg;
    // Direction the setpoint takes on the next tick
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_e;
endpackage

// File: rtl/vramp_tick_gen.sv
// Interval prescaler: emits a one-clock tick every (terminal count + 1) clocks
// while enabled. The count restarts from zero whenever the channel is off.
// Assumes: PROG_INTERVAL=1 takes the count from step_tc_i, otherwise FIXED_TC.
module vramp_tick_gen #(
    parameter int TICK_W        = 10,
    parameter bit PROG_INTERVAL = 1'b1,
    parameter int FIXED_TC      = 999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [TICK_W-1:0] step_tc_i,
    output logic              tick_o
);
    localparam logic [TICK_W-1:0] FIXED_TC_L = TICK_W'(FIXED_TC);

    logic [TICK_W-1:0] term_cnt;
    logic [TICK_W-1:0] cnt_q;

    generate
        if (PROG_INTERVAL) begin : g_prog
            assign term_cnt = step_tc_i;
        end else begin : g_fixed
            logic unused_tc;
            assign unused_tc = ^step_tc_i;
            assign term_cnt  = FIXED_TC_L;
        end
    endgenerate

    // Count clocks and raise the tick on reaching the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == term_cnt) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/vramp_target_sel.sv
// Target selector: picks the preset the ramp heads for.
// Priority: scaling pin (when built in), then standby, then normal.
// Assumes: purely combinational; the presets are stable by the clock edge.
module vramp_target_sel #(
    parameter int CODE_W  = 6,
    parameter bit HAS_DVS = 1'b1
) (
    input  logic              stby_sel_i,
    input  logic              dvs_sel_i,
    input  logic [CODE_W-1:0] tgt_norm_i,
    input  logic [CODE_W-1:0] tgt_stby_i,
    input  logic [CODE_W-1:0] tgt_dvs_i,
    output logic [CODE_W-1:0] tgt_o
);
    logic [CODE_W-1:0] mode_tgt;

    // Standby versus normal preset
    always_comb begin
        mode_tgt = stby_sel_i ? tgt_stby_i : tgt_norm_i;
    end

    generate
        if (HAS_DVS) begin : g_dvs
            // Pin-selected preset overrides the mode preset
            always_comb begin
                tgt_o = dvs_sel_i ? tgt_dvs_i : mode_tgt;
            end
        end else begin : g_no_dvs
            logic unused_dvs;
            assign unused_dvs = dvs_sel_i ^ (^tgt_dvs_i);
            assign tgt_o      = mode_tgt;
        end
    endgenerate
endmodule

// File: rtl/vramp_stepper.sv
// Setpoint stepper: on each tick moves the code one LSB toward the target,
// saturating at both ends. Disabling clears the code on the next clock.
// Assumes: tick_i is a single-cycle pulse; target may change at any cycle.
module vramp_stepper #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] tgt_i,
    output logic [CODE_W-1:0] code_o,
    output logic              busy_o
);
    import vramp_pkg::*;

    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_MIN = '0;

    logic [CODE_W-1:0] code_q;
    logic              en_q;
    step_dir_e         dir;

    // Decide the direction of the next step, honouring the saturation limits
    always_comb begin
        if (code_q < tgt_i && code_q != CODE_MAX) begin
            dir = STEP_UP;
        end else if (code_q > tgt_i && code_q != CODE_MIN) begin
            dir = STEP_DOWN;
        end else begin
            dir = STEP_HOLD;
        end
    end

    // Hold the setpoint and the registered enable
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            code_q <= CODE_MIN;
            en_q   <= 1'b0;
        end else begin
            en_q <= 1'b1;
            if (tick_i) begin
                case (dir)
                    STEP_UP:   code_q <= code_q + 1'b1;
                    STEP_DOWN: code_q <= code_q - 1'b1;
                    default:   code_q <= code_q;
                endcase
            end
        end
    end

    // Drive the outputs: busy only while enabled and away from the target
    always_comb begin
        code_o = code_q;
        busy_o = en_q && (code_q != tgt_i);
    end
endmodule

// File: rtl/vramp_seq.sv
// Top of the voltage ramp sequencer: prescaler, target selector, stepper
// and the range flag register.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module vramp_seq #(
    parameter int CODE_W        = 6,
    parameter int TICK_W        = 10,
    parameter bit PROG_INTERVAL = 1'b1,
    parameter int FIXED_TC      = 999,
    parameter bit HAS_DVS       = 1'b1,
    parameter bit HAS_HIRANGE   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              stby_sel_i,
    input  logic              dvs_sel_i,
    input  logic [CODE_W-1:0] tgt_norm_i,
    input  logic [CODE_W-1:0] tgt_stby_i,
    input  logic [CODE_W-1:0] tgt_dvs_i,
    input  logic              hi_range_i,
    input  logic [TICK_W-1:0] step_tc_i,
    output logic [CODE_W-1:0] code_o,
    output logic              range_o,
    output logic              busy_o
);
    logic              step_tick;
    logic [CODE_W-1:0] sel_tgt;

    vramp_tick_gen #(
        .TICK_W       (TICK_W),
        .PROG_INTERVAL(PROG_INTERVAL),
        .FIXED_TC     (FIXED_TC)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .step_tc_i(step_tc_i),
        .tick_o   (step_tick)
    );

    vramp_target_sel #(
        .CODE_W (CODE_W),
        .HAS_DVS(HAS_DVS)
    ) u_sel (
        .stby_sel_i(stby_sel_i),
        .dvs_sel_i (dvs_sel_i),
        .tgt_norm_i(tgt_norm_i),
        .tgt_stby_i(tgt_stby_i),
        .tgt_dvs_i (tgt_dvs_i),
        .tgt_o     (sel_tgt)
    );

    vramp_stepper #(
        .CODE_W(CODE_W)
    ) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .tick_i(step_tick),
        .tgt_i (sel_tgt),
        .code_o(code_o),
        .busy_o(busy_o)
    );

    generate
        if (HAS_HIRANGE) begin : g_range
            // Register the range select
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    range_o <= 1'b0;
                end else begin
                    range_o <= hi_range_i;
                end
            end
        end else begin : g_single_range
            logic unused_range;
            assign unused_range = hi_range_i;
            assign range_o      = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/vramp_seq_chk.sv
// Property checker for vramp_seq, attached with bind below.
// Assumes: sel_tgt is the internal selected target of the top module.
module vramp_seq_chk #(
    parameter int CODE_W      = 6,
    parameter bit HAS_HIRANGE = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              hi_range_i,
    input logic [CODE_W-1:0] sel_tgt,
    input logic [CODE_W-1:0] code_o,
    input logic              range_o,
    input logic              busy_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    AST_ONE_LSB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i)) |->
            (code_o == $past(code_o) || code_o == $past(code_o) + 1'b1 ||
             code_o == $past(code_o) - 1'b1)); // R2

    AST_UP_ONLY_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && code_o == $past(code_o) + 1'b1) |->
            ($past(code_o) < $past(sel_tgt))); // R7

    AST_DOWN_ONLY_ABOVE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && code_o == $past(code_o) - 1'b1) |->
            ($past(code_o) > $past(sel_tgt))); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && $past(code_o) == CODE_MAX) |->
            (code_o != '0)); // R8

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (code_o == '0 && !busy_o)); // R10

    generate
        if (HAS_HIRANGE) begin : g_rng
            AST_RANGE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (range_o == $past(hi_range_i))); // R11
        end else begin : g_no_rng
            AST_RANGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                hi_range_i |=> !range_o); // R11
        end
    endgenerate
endmodule

bind vramp_seq vramp_seq_chk #(
    .CODE_W     (CODE_W),
    .HAS_HIRANGE(HAS_HIRANGE)
) u_vramp_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .hi_range_i(hi_range_i),
    .sel_tgt   (sel_tgt),
    .code_o    (code_o),
    .range_o   (range_o),
    .busy_o    (busy_o)
);

// File: tb/test_vramp_seq.sv
// Bench for vramp_seq: soft-start sweeps over all targets and several
// intervals, retarget, scaling-pin, saturation, disable and range cases,
// plus a fixed-interval single-range channel.
module test_vramp_seq;
    localparam int CW = 6;
    localparam int TW = 10;
    localparam int FTC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          stby = 1'b0;
    logic          dvs = 1'b0;
    logic [CW-1:0] t_norm = '0;
    logic [CW-1:0] t_stby = '0;
    logic [CW-1:0] t_dvs = '0;
    logic          hi_rng = 1'b0;
    logic [TW-1:0] step_tc = '0;

    logic [CW-1:0] code_a, code_b;
    logic          rng_a, rng_b, busy_a, busy_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vramp_seq #(.CODE_W(CW), .TICK_W(TW), .PROG_INTERVAL(1'b1), .FIXED_TC(FTC),
                .HAS_DVS(1'b1), .HAS_HIRANGE(1'b1)) i_vramp_seq (
        .clk(clk), .rst_n(rst_n), .en_i(en), .stby_sel_i(stby), .dvs_sel_i(dvs),
        .tgt_norm_i(t_norm), .tgt_stby_i(t_stby), .tgt_dvs_i(t_dvs),
        .hi_range_i(hi_rng), .step_tc_i(step_tc),
        .code_o(code_a), .range_o(rng_a), .busy_o(busy_a));

    vramp_seq #(.CODE_W(CW), .TICK_W(TW), .PROG_INTERVAL(1'b0), .FIXED_TC(FTC),
                .HAS_DVS(1'b0), .HAS_HIRANGE(1'b0)) i_vramp_seq_fixed (
        .clk(clk), .rst_n(rst_n), .en_i(en), .stby_sel_i(stby), .dvs_sel_i(dvs),
        .tgt_norm_i(t_norm), .tgt_stby_i(t_stby), .tgt_dvs_i(t_dvs),
        .hi_range_i(hi_rng), .step_tc_i(step_tc),
        .code_o(code_b), .range_o(rng_b), .busy_o(busy_b));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Turn the channel off for a few clocks so the prescaler restarts
    task automatic go_off();
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Soft start from zero; compare every cycle with the closed-form tick count
    task automatic soft_start(input string req, input int tgt, input int tc,
                              input bit fixed_ch);
        int steps, exp_code, lim;
        en = 1'b1;
        lim = (tgt + 2) * (tc + 1) + 4;
        for (int n = 1; n <= lim; n++) begin
            @(negedge clk);
            steps = (n >= tc + 2) ? ((n - tc - 2) / (tc + 1)) + 1 : 0;
            exp_code = (steps < tgt) ? steps : tgt;
            if (fixed_ch) begin
                check(req, int'(code_b), exp_code);
            end else begin
                check(req, int'(code_a), exp_code);
                check("R9 busy", int'(busy_a), int'(exp_code != tgt));
            end
        end
    endtask

    // Follow a ramp on the main channel: unit steps toward tgt, fixed spacing
    task automatic follow(input string req, input int tgt, input int tc,
                          input int last_in);
        int prev, cur, last, lim;
        prev = int'(code_a);
        last = last_in;
        lim = 70 * (tc + 1) + 8;
        for (int n = 1; n <= lim; n++) begin
            @(negedge clk);
            cur = int'(code_a);
            if (cur != prev) begin
                check({req, " unit step"}, (cur > prev) ? cur - prev : prev - cur, 1);
                check({req, " direction"}, int'(cur > prev), int'(tgt > prev));
                if (last >= 0) check({req, " spacing"}, n - last, tc + 1);
                last = n;
                prev = cur;
            end
            if (cur == tgt && !busy_a) break;
        end
        check({req, " reached"}, int'(code_a), tgt);
        check("R9 busy at target", int'(busy_a), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int last_chg;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 code", int'(code_a), 0);
        check("R1 busy", int'(busy_a), 0);
        check("R1 range", int'(rng_a), 0);
        rst_n = 1'b1;
        t_norm = 6'd20;
        repeat (3) @(negedge clk);
        check("R1 idle code", int'(code_a), 0);
        check("R1 idle busy", int'(busy_a), 0);

        // R2 R3 R8 R9: soft start over all targets and intervals 0..3
        for (int tc = 0; tc < 4; tc++) begin
            for (int tg = 0; tg < 64; tg++) begin
                go_off();
                step_tc = TW'(tc);
                t_norm = CW'(tg);
                soft_start("R3 soft start", tg, tc, 1'b0);
            end
        end

        // R5: standby preset ramps down, then R8 floor at zero
        step_tc = TW'(1);
        t_stby = 6'd0;
        @(negedge clk);
        stby = 1'b1;
        follow("R5 standby", 0, 1, -1);
        repeat (6) @(negedge clk);
        check("R8 floor hold", int'(code_a), 0);

        // R5: scaling pin wins over standby; back to standby when released
        t_dvs = 6'd45;
        t_stby = 6'd12;
        dvs = 1'b1;
        follow("R5 pin", 45, 1, -1);
        dvs = 1'b0;
        follow("R5 release", 12, 1, -1);
        stby = 1'b0;
        t_norm = 6'd30;
        follow("R5 normal", 30, 1, -1);

        // R7: reversal in the middle of a ramp
        go_off();
        step_tc = TW'(2);
        t_norm = 6'd40;
        t_stby = 6'd5;
        en = 1'b1;
        last_chg = 0;
        while (code_a != 6'd20) @(negedge clk);
        stby = 1'b1;
        for (int n = 1; n <= 4; n++) begin
            @(negedge clk);
            if (code_a != 6'd20) begin
                check("R7 reverse code", int'(code_a), 19);
                check("R7 reverse spacing", n, 3);
                last_chg = n;
                break;
            end
        end
        check("R7 changed", int'(code_a), 19);
        follow("R7 retarget", 5, 2, 0);
        stby = 1'b0;

        // R10: disable mid ramp clears on the next clock
        t_norm = 6'd50;
        repeat (20) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R10 code", int'(code_a), 0);
        check("R10 busy", int'(busy_a), 0);

        // R11: range follows one clock later; single-range channel stays low
        for (int k = 0; k < 4; k++) begin
            hi_rng = k[0];
            check("R11 before edge", int'(rng_a), int'(~k[0]) & int'(k != 0));
            @(negedge clk);
            check("R11 follows", int'(rng_a), int'(k[0]));
            check("R11 single range", int'(rng_b), 0);
        end

        // R4 R6: fixed channel ignores step_tc_i and the scaling pin
        go_off();
        step_tc = TW'(0);
        stby = 1'b0;
        dvs = 1'b1;
        t_dvs = 6'd60;
        t_norm = 6'd9;
        soft_start("R4 fixed interval", 9, FTC, 1'b1);
        check("R6 pin ignored", int'(code_b), 9);
        check("R6 busy", int'(busy_b), 0);
        go_off();
        step_tc = TW'(7);
        t_norm = 6'd3;
        soft_start("R4 fixed ignores field", 3, FTC, 1'b1);
        dvs = 1'b0;
        report();
    end
endmodule